// File: doc/BRIEF.md
# Single-Pulse Generator with Memory

This block turns a level on a trigger input into one clock-wide strobe. Each time the trigger is sampled high after being sampled low, the strobe output goes high for exactly one clock period. The block then waits until the trigger is sampled low again before it can fire again. A trigger held high for any length of time therefore gives one strobe and no more.

A second output, the done flag, shows that the strobe for the current trigger excursion has already been issued. It is raised in the two states that follow the strobe. It is qualified by an enable input, so it reads high only while that enable is high. It drops once the trigger has been seen low and the machine is back in idle.

The state is held in two registers, called hi and lo. Their next values come from sum-of-products equations, and a synchronous active-high clear is ANDed into those equations.

Top module: `spg_top`

## Requirements
- R1: While `rst` is high, `pulse_o` reads 0. A rising clock edge with `rst` high puts the machine in idle, with both state bits 0.
- R2: State bits {hi,lo} are encoded as follows: idle 00, fire 10, hold 11, wait 01. From idle the machine moves to fire on a rising edge only if `trig_in` is sampled 1. Otherwise it stays in idle.
- R3: Fire always moves to hold on the next edge, and hold always moves to wait on the next edge, whatever the value of `trig_in`.
- R4: In wait the machine stays while `trig_in` is sampled 1. It returns to idle on the edge where `trig_in` is sampled 0.
- R5: `pulse_o` is high only in fire. It is never high for two consecutive cycles.
- R6: `done_o` is high exactly when the state is hold or wait and `flag_en` is 1. It follows `flag_en` within the same cycle.
- R7: A high excursion on `trig_in` that begins and ends between two rising edges has no effect: `pulse_o` stays 0.
- R8: A trigger held high for many cycles produces exactly one `pulse_o` cycle. A further pulse needs `trig_in` to be sampled 0 and then 1 again.
- R9: While `rst` is high, `done_o` still reflects the current state and `flag_en` until the clearing edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear to idle |
| trig_in | input | 1 | Trigger level, sampled at each rising edge |
| flag_en | input | 1 | Enable that qualifies the done flag |
| pulse_o | output | 1 | One-cycle strobe, high in fire |
| done_o | output | 1 | Strobe-issued flag, high in hold or wait while enabled |

## Verification
A vector walk drives single-cycle, two-cycle and long trigger excursions. These show whether the strobe width is tied to the machine's states or to the length of the trigger. Toggling the enable while in the hold and wait states shows whether the done flag is Mealy-qualified or a pure state decode. A sub-cycle glitch shows whether the trigger is sampled only at the clock edge. A very long hold followed by a release and a new press shows that the block re-arms only after a low sample. Clears applied in fire and in hold show that the strobe is forced off immediately, while the flag survives until the clearing edge.

// File: rtl/spg_pkg.sv
package spg_pkg;

    localparam int PHASE_W = 2;

    // bit 1 = hi register, bit 0 = lo register
    typedef enum logic [PHASE_W-1:0] {
        PH_IDLE = 2'b00,
        PH_FIRE = 2'b10,
        PH_HOLD = 2'b11,
        PH_WAIT = 2'b01
    } phase_e;

    typedef struct packed {
        logic pulse;
        logic done;
    } outs_t;

    // Sum-of-products next state with the clear ANDed in
    function automatic phase_e next_phase(phase_e cur, logic trig, logic clr);
        logic hi;
        logic lo;
        logic d_hi;
        logic d_lo;
        hi   = cur[1];
        lo   = cur[0];
        d_hi = ((hi & ~lo) | (~lo & trig)) & ~clr;
        d_lo = (hi | (lo & trig)) & ~clr;
        return phase_e'({d_hi, d_lo});
    endfunction

endpackage

// File: rtl/spg_next.sv
module spg_next
    import spg_pkg::*;
(
    input  phase_e cur,
    input  logic   trig,
    input  logic   clr,
    output phase_e nxt
);
    always_comb begin
        nxt = next_phase(cur, trig, clr);
    end
endmodule

// File: rtl/spg_state_reg.sv
module spg_state_reg
    import spg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   trig,
    input  phase_e d,
    output phase_e q
);
    always_ff @(posedge clk) begin
        q <= d;
    end

    a_r1_clear_to_idle: assert property (@(posedge clk)
        rst |=> (q == PH_IDLE));

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (q == PH_IDLE && !trig) |=> (q == PH_IDLE));

    a_r2_idle_fire: assert property (@(posedge clk) disable iff (rst)
        (q == PH_IDLE && trig) |=> (q == PH_FIRE));

    a_r3_fire_to_hold: assert property (@(posedge clk) disable iff (rst)
        (q == PH_FIRE) |=> (q == PH_HOLD));

    a_r3_hold_to_wait: assert property (@(posedge clk) disable iff (rst)
        (q == PH_HOLD) |=> (q == PH_WAIT));

    a_r4_wait_stay: assert property (@(posedge clk) disable iff (rst)
        (q == PH_WAIT && trig) |=> (q == PH_WAIT));

    a_r4_wait_release: assert property (@(posedge clk) disable iff (rst)
        (q == PH_WAIT && !trig) |=> (q == PH_IDLE));
endmodule

// File: rtl/spg_out_dec.sv
module spg_out_dec
    import spg_pkg::*;
(
    input  phase_e ph,
    input  logic   en,
    input  logic   clr,
    output outs_t  o
);
    always_comb begin
        o.pulse = ph[1] & ~ph[0] & ~clr;
        o.done  = ph[0] & en;
    end
endmodule

// File: rtl/spg_top.sv
module spg_top
    import spg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic trig_in,
    input  logic flag_en,
    output logic pulse_o,
    output logic done_o
);
    phase_e ph_q;
    phase_e ph_d;
    outs_t  outs;

    spg_next u_next (
        .cur  (ph_q),
        .trig (trig_in),
        .clr  (rst),
        .nxt  (ph_d)
    );

    spg_state_reg u_state (
        .clk  (clk),
        .rst  (rst),
        .trig (trig_in),
        .d    (ph_d),
        .q    (ph_q)
    );

    spg_out_dec u_dec (
        .ph  (ph_q),
        .en  (flag_en),
        .clr (rst),
        .o   (outs)
    );

    assign pulse_o = outs.pulse;
    assign done_o  = outs.done;

    a_r1_no_pulse_in_clear: assert property (@(posedge clk)
        rst |-> !pulse_o);

    a_r5_one_cycle_wide: assert property (@(posedge clk) disable iff (rst)
        pulse_o |=> !pulse_o);

    a_r5_pulse_needs_trig: assert property (@(posedge clk) disable iff (rst)
        pulse_o |-> $past(trig_in));

    a_r6_flag_gated: assert property (@(posedge clk) disable iff (rst)
        !flag_en |-> !done_o);

    a_r6_flag_after_pulse: assert property (@(posedge clk) disable iff (rst)
        (pulse_o && flag_en) |=> (done_o || !flag_en));
endmodule

// File: tb/spg_top_tb_top.sv
module spg_top_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic trig_in = 1'b0;
    logic flag_en = 1'b1;
    logic pulse_o;
    logic done_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    spg_top dut_i (
        .clk     (clk),
        .rst     (rst),
        .trig_in (trig_in),
        .flag_en (flag_en),
        .pulse_o (pulse_o),
        .done_o  (done_o)
    );

    // {trig, en, expected pulse, expected done}, checked 1 ns after the edge
    localparam logic [3:0] VEC [20] = '{
        4'b0100, 4'b1110, 4'b1101, 4'b1101, 4'b1101,
        4'b1000, 4'b0000, 4'b0100, 4'b1110, 4'b0101,
        4'b0101, 4'b0100, 4'b1110, 4'b0101, 4'b1101,
        4'b0100, 4'b1010, 4'b1000, 4'b1101, 4'b0100
    };

    task automatic check(input string req, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0b exp=%0b t=%0t", req, got, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int pulses;
        // R1 reset state
        step();
        step();
        check("R1 reset pulse", pulse_o, 1'b0);
        check("R9 reset done", done_o, 1'b0);
        rst = 1'b0;

        // vector walk: R2 R3 R4 R5 R6
        for (int i = 0; i < 20; i++) begin
            trig_in = VEC[i][3];
            flag_en = VEC[i][2];
            step();
            check($sformatf("R2/R3/R4/R5 pulse vec%0d", i), pulse_o, VEC[i][1]);
            check($sformatf("R6 done vec%0d", i), done_o, VEC[i][0]);
        end

        // R6: flag follows enable within the cycle (machine in wait)
        trig_in = 1'b1; flag_en = 1'b1;
        step(); step(); step();
        flag_en = 1'b0; #0.5;
        check("R6 done drops with enable", done_o, 1'b0);
        flag_en = 1'b1; #0.5;
        check("R6 done rises with enable", done_o, 1'b1);
        trig_in = 1'b0;
        step();
        check("R4 back to idle", done_o, 1'b0);

        // R7 glitch between edges
        trig_in = 1'b1; #1; trig_in = 1'b0;
        step();
        check("R7 glitch ignored", pulse_o, 1'b0);
        step();
        check("R7 glitch no flag", done_o, 1'b0);

        // R8 long hold: one pulse only
        pulses = 0;
        trig_in = 1'b1;
        for (int k = 0; k < 40; k++) begin
            step();
            if (pulse_o === 1'b1) pulses++;
        end
        check("R8 single pulse on long hold", pulses == 1, 1'b1);
        trig_in = 1'b0;
        step();
        trig_in = 1'b1;
        step();
        check("R8 re-arm after low sample", pulse_o, 1'b1);
        trig_in = 1'b0;
        step(); step(); step();

        // R1 clear while in fire: pulse forced low at once
        trig_in = 1'b1;
        step();
        check("R1 in fire before clear", pulse_o, 1'b1);
        rst = 1'b1; #0.5;
        check("R1 pulse low during clear", pulse_o, 1'b0);
        step();
        check("R1 idle after clear (done)", done_o, 1'b0);
        rst = 1'b0;
        trig_in = 1'b0;
        step();
        check("R1 idle after clear (pulse)", pulse_o, 1'b0);

        // R9 clear while in hold: flag survives until edge
        trig_in = 1'b1; flag_en = 1'b1;
        step(); step();
        check("R9 in hold", done_o, 1'b1);
        rst = 1'b1; #0.5;
        check("R9 done held during clear", done_o, 1'b1);
        step();
        check("R9 done clears at edge", done_o, 1'b0);
        rst = 1'b0;
        trig_in = 1'b0;
        step();

        summary();
    end
endmodule